// File: doc/BRIEF.md
# Cascadable Dual 8-bit Event Counter

The block holds two 8-bit up-counters, a low half and a high half. Software can read them but cannot load them. Each half picks what makes it count through a 3-bit select field. The choices are a rising edge on its own external event pin, or one of three enable pulses that a free-running prescaler derives from the system clock at one half, one quarter and one eighth of its rate. The high half has a fifth choice: it can count the low half's wrap-around, and then the two halves form one 16-bit event counter with the low half as the low byte.

Each half has its own run-control input. While that input is 0 the half is held at zero; it counts only while the input is 1. Both count values are available as plain outputs. They can also be read through a small read port. When the port reads the low byte, it latches the high byte into a snapshot register at the same time, so that software can assemble a coherent 16-bit value while the pair is cascaded.

Event pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser and a rising-edge detector before it reaches the counter. All counting runs on the single system clock, using clock enables and no derived clocks.

Top module: `evtcnt_pair`

## Requirements
- R1: While reset is asserted, both counts, the snapshot register and the read data at every address are 0x00.
- R2: A half whose run input is 0 reads 0x00 after the next clock edge and stays there. It counts only while its run input is 1.
- R3: With select code 0, a half counts rising edges of its own event pin, once per edge however long the pin stays high. The count changes on the second clock edge after the edge that first samples the pin high.
- R4: Select codes 1, 2 and 3 advance a half on edges where a free-running 3-bit prescaler, 0 at reset and stepping once per clock, holds a value whose low 1, 2 or 3 bits are all ones. This gives one count per 2, 4 or 8 clocks.
- R5: With select code 4 the high half advances on the same clock edge on which the low half wraps from 0xFF to 0x00.
- R6: Select codes 5 to 7 on either half, and code 4 on the low half, stop that half. It keeps its value and ignores its pin and the prescaler.
- R7: Each half wraps from 0xFF to 0x00 without saturating.
- R8: The read port returns the low count at address 0, the live high count at address 1, the snapshot at address 2, and 0x00 at address 3. A read strobe at address 0 copies the high count into the snapshot on that clock edge.
- R9: The run input and select field of one half have no effect on the other half, except through the overflow chain of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| lo_evt_i | input | 1 | Asynchronous event pin of the low half |
| hi_evt_i | input | 1 | Asynchronous event pin of the high half |
| lo_run_i | input | 1 | Run control of the low half (0 holds it at zero) |
| hi_run_i | input | 1 | Run control of the high half (0 holds it at zero) |
| lo_sel_i | input | 3 | Count source of the low half |
| hi_sel_i | input | 3 | Count source of the high half |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data |
| lo_count_o | output | 8 | Current low count |
| hi_count_o | output | 8 | Current high count |

## Verification
The bench builds the block with its default values: 8-bit halves, a 3-bit prescaler and a two-stage synchroniser. These sizes keep a low-half wrap within 512 clocks at the fastest rate, so the bench can reach a wrap of the standalone high half and several carries into the cascaded high byte in a short run. Pin patterns with one-cycle pulses and long high levels test edge counting. Read strobes go to every address on a rotating pattern, so snapshots are taken while carries are passing.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned NUM_DIV = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_PIN   = 3'd0,
    SRC_DIV2  = 3'd1,
    SRC_DIV4  = 3'd2,
    SRC_DIV8  = 3'd3,
    SRC_CHAIN = 3'd4
  } src_sel_e;

  typedef enum logic [1:0] {
    RA_LOW  = 2'd0,
    RA_HIGH = 2'd1,
    RA_SNAP = 2'd2,
    RA_NONE = 2'd3
  } rd_addr_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  localparam int unsigned SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R3: one detected edge lasts exactly one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int unsigned PRE_W = evtcnt_pkg::NUM_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PRE_W-1:0] tick_o
);
  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar i = 0; i < PRE_W; i++) begin : g_tick
    assign tick_o[i] = &pre_q[i:0];
  end

  // R4: the fastest tick alternates, the slowest never repeats back to back
  a_r4_div2_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o[0] |=> !tick_o[0]);
  a_r4_slow_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o[PRE_W-1] |=> !tick_o[PRE_W-1]);
endmodule

// File: rtl/evt_half.sv
module evt_half
  import evtcnt_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter bit          CHAIN = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               pin_rise_i,
  input  logic [NUM_DIV-1:0] div_tick_i,
  input  logic               chain_i,
  output logic [W-1:0]       cnt_o,
  output logic               ovf_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         src_hit;
  logic         inc;
  logic         bad_code;

  always_comb begin
    case (src_sel_e'(sel_i))
      SRC_PIN:   src_hit = pin_rise_i;
      SRC_DIV2:  src_hit = div_tick_i[0];
      SRC_DIV4:  src_hit = div_tick_i[1];
      SRC_DIV8:  src_hit = div_tick_i[2];
      SRC_CHAIN: src_hit = CHAIN & chain_i;
      default:   src_hit = 1'b0;
    endcase
  end

  assign inc = run_i & src_hit;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)   cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = inc & (cnt_q == CNT_MAX);

  assign bad_code = (sel_i > SEL_W'(SRC_CHAIN)) ||
                    (!CHAIN && sel_i == SEL_W'(SRC_CHAIN));

  // R2: run low forces zero
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_o == '0);
  // R7: overflow is followed by zero
  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> cnt_o == '0);
  // R7: a running half moves by at most one
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
  // R6: unused code holds the count
  a_r6_bad_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && bad_code) |=> cnt_o == $past(cnt_o));
endmodule

// File: rtl/evtcnt_pair.sv
module evtcnt_pair
  import evtcnt_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lo_evt_i,
  input  logic             hi_evt_i,
  input  logic             lo_run_i,
  input  logic             hi_run_i,
  input  logic [2:0]       lo_sel_i,
  input  logic [2:0]       hi_sel_i,
  input  logic             rd_en_i,
  input  logic [1:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic [CNT_W-1:0] lo_count_o,
  output logic [CNT_W-1:0] hi_count_o
);
  localparam int unsigned NPIN = 2;

  logic [NPIN-1:0]    pins;
  logic [NPIN-1:0]    rises;
  logic [NUM_DIV-1:0] ticks;
  logic               lo_ovf;
  logic               hi_ovf_unused;
  logic [CNT_W-1:0]   lo_cnt, hi_cnt;
  logic [CNT_W-1:0]   snap_q, snap_d;
  logic               snap_en;

  assign pins = {hi_evt_i, lo_evt_i};

  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    evt_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pins[p]),
      .rise_o (rises[p])
    );
  end

  evt_prescaler #(.PRE_W(NUM_DIV)) i_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (ticks)
  );

  evt_half #(.W(CNT_W), .CHAIN(1'b0)) i_lo (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (lo_run_i),
    .sel_i      (lo_sel_i),
    .pin_rise_i (rises[0]),
    .div_tick_i (ticks),
    .chain_i    (1'b0),
    .cnt_o      (lo_cnt),
    .ovf_o      (lo_ovf)
  );

  evt_half #(.W(CNT_W), .CHAIN(1'b1)) i_hi (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (hi_run_i),
    .sel_i      (hi_sel_i),
    .pin_rise_i (rises[1]),
    .div_tick_i (ticks),
    .chain_i    (lo_ovf),
    .cnt_o      (hi_cnt),
    .ovf_o      (hi_ovf_unused)
  );

  assign snap_en = rd_en_i && (rd_addr_i == 2'(RA_LOW));

  always_comb begin
    snap_d = snap_q;
    if (snap_en) snap_d = hi_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  always_comb begin
    case (rd_addr_e'(rd_addr_i))
      RA_LOW:  rd_data_o = lo_cnt;
      RA_HIGH: rd_data_o = hi_cnt;
      RA_SNAP: rd_data_o = snap_q;
      default: rd_data_o = '0;
    endcase
  end

  assign lo_count_o = lo_cnt;
  assign hi_count_o = hi_cnt;

  // R5: high half follows the low wrap in cascade mode
  a_r5_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_run_i && hi_sel_i == 3'(SRC_CHAIN) && lo_ovf) |=> hi_count_o == $past(hi_count_o) + 1'b1);
  // R8: a low read captures the high byte
  a_r8_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> snap_q == $past(hi_count_o));
  // R8: address 3 reads zero
  a_r8_empty_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_i == 2'(RA_NONE) |-> rd_data_o == '0);
endmodule

// File: tb/test_evtcnt_pair.sv
module test_evtcnt_pair;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       lo_evt, hi_evt, lo_run, hi_run, rd_en;
  logic [2:0] lo_sel, hi_sel;
  logic [1:0] rd_addr;
  logic [7:0] rd_data, lo_count, hi_count;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  evtcnt_pair i_evtcnt_pair (
    .clk(clk), .rst_n(rst_n), .lo_evt_i(lo_evt), .hi_evt_i(hi_evt),
    .lo_run_i(lo_run), .hi_run_i(hi_run), .lo_sel_i(lo_sel), .hi_sel_i(hi_sel),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .lo_count_o(lo_count), .hi_count_o(hi_count)
  );

  // reference model
  int m_lo, m_hi, m_snap, m_k;
  int lh1, lh2, lh3, hh1, hh2, hh3;

  function automatic bit picks(int sel, bit e, int k, bit ovf, bit chain);
    case (sel)
      0: return e;
      1: return (k % 2) == 1;
      2: return (k % 4) == 3;
      3: return (k % 8) == 7;
      4: return chain && ovf;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_snap = 0; m_k = 0;
      lh1 = 0; lh2 = 0; lh3 = 0; hh1 = 0; hh2 = 0; hh3 = 0;
    end else begin
      bit le, he, li, hi_inc, ovf;
      le = (lh2 == 1) && (lh3 == 0);
      he = (hh2 == 1) && (hh3 == 0);
      lh3 = lh2; lh2 = lh1; lh1 = lo_evt;
      hh3 = hh2; hh2 = hh1; hh1 = hi_evt;
      li     = lo_run && picks(lo_sel, le, m_k, 1'b0, 1'b0);
      ovf    = li && (m_lo == 255);
      hi_inc = hi_run && picks(hi_sel, he, m_k, ovf, 1'b1);
      if (rd_en && rd_addr == 2'd0) m_snap = m_hi;
      if (!lo_run) m_lo = 0; else if (li) m_lo = (m_lo + 1) % 256;
      if (!hi_run) m_hi = 0; else if (hi_inc) m_hi = (m_hi + 1) % 256;
      m_k = (m_k + 1) % 8;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd();
    case (rd_addr)
      2'd0: return m_lo;
      2'd1: return m_hi;
      2'd2: return m_snap;
      default: return 0;
    endcase
  endfunction

  int cyc = 0;
  int pin_mode = 0;

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk({tag, " low count"},  lo_count, m_lo);
      chk({tag, " high count"}, hi_count, m_hi);
      chk({tag, " R8 read"},    rd_data,  exp_rd());
      cyc++;
      rd_addr = 2'(cyc % 4);
      rd_en   = (cyc % 3) == 0;
      case (pin_mode)
        1: begin lo_evt = (cyc % 7) < 3;  hi_evt = (cyc % 5) == 0; end
        2: begin lo_evt = (cyc % 23) < 15; hi_evt = (cyc % 9) < 2; end
        default: begin lo_evt = 1'b0; hi_evt = 1'b0; end
      endcase
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lo_evt = 0; hi_evt = 0; lo_run = 0; hi_run = 0;
    lo_sel = 0; hi_sel = 0; rd_en = 0; rd_addr = 0;
    // R1: reset state at every read address
    repeat (2) @(negedge clk);
    lo_run = 1; hi_run = 1; lo_sel = 1; hi_sel = 1;
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); rd_en = 1;
      @(negedge clk);
      chk("R1 reset read", rd_data, 0);
      chk("R1 reset low", lo_count, 0);
      chk("R1 reset high", hi_count, 0);
    end
    rd_en = 0; rd_addr = 0;
    rst_n = 1'b1;
    // R4: prescaled rates
    lo_sel = 1; hi_sel = 2; run(40, "R4 div2/div4");
    lo_sel = 3; hi_sel = 3; run(40, "R4 div8");
    // R3: external edges, short pulses then long levels
    lo_sel = 0; hi_sel = 0; pin_mode = 1; run(70, "R3 pin pulses");
    pin_mode = 2; run(90, "R3 pin levels");
    // R2 R9: clearing one half leaves the other counting
    lo_run = 0; run(12, "R2 R9 low cleared");
    lo_run = 1; hi_run = 0; run(12, "R2 R9 high cleared");
    hi_run = 1;
    // R6: unused codes stop the count
    lo_sel = 5; hi_sel = 7; run(30, "R6 codes 5 7");
    lo_sel = 4; hi_sel = 6; run(30, "R6 low code 4");
    // R5 R7: cascade with wraps of the low half
    pin_mode = 0; lo_sel = 1; hi_sel = 4; run(1300, "R5 R7 cascade");
    // R7: standalone high wrap
    hi_sel = 1; run(560, "R7 high wrap");
    chk("R7 high wrapped below start", (hi_count < 200) ? 1 : 0, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule